// File: doc/BRIEF.md
# Timestamp Snapshot Serializer

This block keeps a free-running real-time clock. The clock has a 32-bit seconds count and a 20-bit microseconds count. The microseconds count advances on a single-cycle tick input. When it passes its last value it returns to zero and carries into the seconds count.

A client, for example an event logger, asks for the current time by pulsing a snapshot input. Both counts are captured together on that clock edge. The block then raises a one-cycle lead-in strobe and sends an eight-byte message on a byte-wide bus. The message starts with the four seconds bytes and ends with the four microseconds bytes. Each field is sent least significant byte first, and the final byte is always zero.

A busy output covers the whole exchange. Any snapshot request made while busy is high is discarded.

Top module: `ts_snapshot_serializer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, the outputs read idle: `stamp_stb` is 0, `busy` is 0 and `stamp_byte` is 0. Both time counts are zero.
- R2: Each cycle with `usec_tick` high increments the microseconds count. From `USEC_LIMIT-1` (default 999999) it returns to 0, and in that same cycle the seconds count increments by one.
- R3: An accepted request captures the seconds and microseconds counts held before that clock edge as one coherent pair. A tick on the same edge does not alter the captured pair.
- R4: `stamp_stb` is high for exactly the one cycle after the accepting edge. That is one clock before the first message byte.
- R5: The message bytes are seconds[7:0], [15:8], [23:16], [31:24], then microseconds[7:0], [15:8], then a byte whose upper nibble is 0 and whose lower nibble is microseconds[19:16].
- R6: The eighth message byte is always 0x00.
- R7: The eight bytes appear on eight consecutive cycles with no gap. `stamp_byte` is 0 in every cycle that is not a message byte.
- R8: `busy` rises with the strobe and stays high through the cycle of the eighth byte. It falls in the next cycle.
- R9: A request seen on an edge while `busy` is high has no effect: no strobe follows and the message in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usec_tick | input | 1 | One-cycle pulse that advances the microseconds count |
| snap_req | input | 1 | Snapshot request, sampled on each rising edge |
| stamp_stb | output | 1 | One-cycle lead-in strobe before the first byte |
| stamp_byte | output | 8 | Message byte bus, zero when idle |
| busy | output | 1 | High from the accepting edge through the last byte |

## Verification
A corrupted byte index or message register shows up within the eight-byte window of the next message: bytes come out misordered, shifted or non-zero where zero is required. A fault in the capture timing appears as a snapshot that is one tick off from the reference pair, and it is most visible when a request lands on a microseconds wrap. A wrong sequencer state shows within one cycle as a strobe that is missing or doubled, a busy level that is wrong, or a non-zero idle bus. The reference model compares every output on every cycle, so each such fault is reported in the cycle it first appears.

// File: rtl/ts_pkg.sv
// Shared constants and types for the timestamp snapshot serializer.
// Assumes byte-wide messages; all users derive field sizes from BYTE_W.
package ts_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LEAD = 2'd1,
        SEQ_SEND = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ts_rtc_counter.sv
// Seconds/microseconds real-time counter.
// Microseconds advance on usec_tick, wrap at USEC_LIMIT-1 and carry into
// seconds in the same cycle. Assumes USEC_LIMIT fits in USEC_W bits.
module ts_rtc_counter #(
    parameter int SEC_W      = 32,
    parameter int USEC_W     = 20,
    parameter int USEC_LIMIT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usec_tick,
    output logic [SEC_W-1:0]  sec_o,
    output logic [USEC_W-1:0] usec_o
);
    localparam logic [USEC_W-1:0] USEC_LAST = USEC_W'(USEC_LIMIT - 1);

    logic usec_wrap;
    assign usec_wrap = usec_tick && (usec_o == USEC_LAST);

    // Microseconds count with wrap back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            usec_o <= '0;
        else if (usec_wrap)
            usec_o <= '0;
        else if (usec_tick)
            usec_o <= usec_o + USEC_W'(1);
    end

    // Seconds count, carried from the microseconds wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_o <= '0;
        else if (usec_wrap)
            sec_o <= sec_o + SEC_W'(1);
    end
endmodule

// File: rtl/ts_snapshot_capture.sv
// Captures seconds and microseconds together on load and lays them out as
// the message word: seconds field in the low bytes, zero-extended
// microseconds field in the high bytes. Assumes USEC_W leaves the top
// byte of the microseconds field empty.
module ts_snapshot_capture #(
    parameter int SEC_W     = 32,
    parameter int USEC_W    = 20,
    parameter int MSG_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [SEC_W-1:0]              sec_i,
    input  logic [USEC_W-1:0]             usec_i,
    output logic [MSG_BYTES*ts_pkg::BYTE_W-1:0] msg_o
);
    localparam int MSG_W        = MSG_BYTES * ts_pkg::BYTE_W;
    localparam int SEC_BYTES    = (SEC_W + ts_pkg::BYTE_W - 1) / ts_pkg::BYTE_W;
    localparam int SEC_FIELD_W  = SEC_BYTES * ts_pkg::BYTE_W;
    localparam int USEC_FIELD_W = MSG_W - SEC_FIELD_W;

    // Single-edge capture of both counts into the message word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            msg_o <= '0;
        else if (load)
            msg_o <= {USEC_FIELD_W'(usec_i), SEC_FIELD_W'(sec_i)};
    end
endmodule

// File: rtl/ts_byte_sequencer.sv
// Emits a lead-in strobe, then MSG_BYTES bytes of msg_i, LSB byte first,
// on consecutive cycles. Accepts a request only when idle. Assumes msg_i
// is stable from the cycle after acceptance to the end of the message.
module ts_byte_sequencer #(
    parameter int MSG_BYTES = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req,
    input  logic [MSG_BYTES*ts_pkg::BYTE_W-1:0] msg_i,
    output logic                                accept_o,
    output logic                                stb_o,
    output logic [ts_pkg::BYTE_W-1:0]           byte_o,
    output logic                                busy_o
);
    import ts_pkg::*;

    localparam int IDX_W = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1;
    localparam int CNT_W = $clog2(MSG_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MSG_BYTES);

    seq_state_t             state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [BYTE_W-1:0]      msg_bytes [MSG_BYTES];

    // Slice the message word into an indexable byte array.
    for (genvar gi = 0; gi < MSG_BYTES; gi++) begin : g_slice
        assign msg_bytes[gi] = msg_i[gi*BYTE_W +: BYTE_W];
    end

    assign accept_o = req && (state_q == SEQ_IDLE);
    assign busy_o   = (state_q != SEQ_IDLE);

    // State, byte counter, strobe and output byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            stb_o   <= 1'b0;
            byte_o  <= '0;
        end else begin
            stb_o <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    byte_o <= '0;
                    if (accept_o) begin
                        state_q <= SEQ_LEAD;
                        stb_o   <= 1'b1;
                    end
                end
                SEQ_LEAD: begin
                    byte_o  <= msg_bytes[0];
                    cnt_q   <= CNT_W'(1);
                    state_q <= SEQ_SEND;
                end
                SEQ_SEND: begin
                    if (cnt_q == CNT_LAST) begin
                        byte_o  <= '0;
                        cnt_q   <= '0;
                        state_q <= SEQ_IDLE;
                    end else begin
                        byte_o <= msg_bytes[cnt_q[IDX_W-1:0]];
                        cnt_q  <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    byte_o  <= '0;
                    cnt_q   <= '0;
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ts_snapshot_serializer.sv
// Top: real-time clock plus snapshot-to-byte-stream serializer.
// A request accepted while idle captures both counts on that edge, pulses
// stamp_stb for one cycle, then streams MSG_BYTES bytes.
module ts_snapshot_serializer #(
    parameter int SEC_W      = 32,
    parameter int USEC_W     = 20,
    parameter int USEC_LIMIT = 1000000,
    parameter int MSG_BYTES  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       usec_tick,
    input  logic       snap_req,
    output logic       stamp_stb,
    output logic [7:0] stamp_byte,
    output logic       busy
);
    localparam int MSG_W = MSG_BYTES * ts_pkg::BYTE_W;

    logic [SEC_W-1:0]  sec_now;
    logic [USEC_W-1:0] usec_now;
    logic [MSG_W-1:0]  snap_msg;
    logic              snap_accept;

    ts_rtc_counter #(
        .SEC_W(SEC_W), .USEC_W(USEC_W), .USEC_LIMIT(USEC_LIMIT)
    ) u_rtc (
        .clk(clk), .rst_n(rst_n), .usec_tick(usec_tick),
        .sec_o(sec_now), .usec_o(usec_now)
    );

    ts_snapshot_capture #(
        .SEC_W(SEC_W), .USEC_W(USEC_W), .MSG_BYTES(MSG_BYTES)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .load(snap_accept),
        .sec_i(sec_now), .usec_i(usec_now), .msg_o(snap_msg)
    );

    ts_byte_sequencer #(
        .MSG_BYTES(MSG_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(snap_req), .msg_i(snap_msg),
        .accept_o(snap_accept), .stb_o(stamp_stb),
        .byte_o(stamp_byte), .busy_o(busy)
    );
endmodule

// File: rtl/ts_snapshot_checker.sv
// Protocol and counter checks for ts_snapshot_serializer, bound to the top.
module ts_snapshot_checker #(
    parameter int SEC_W      = 32,
    parameter int USEC_W     = 20,
    parameter int USEC_LIMIT = 1000000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usec_tick,
    input logic              snap_req,
    input logic              stamp_stb,
    input logic [7:0]        stamp_byte,
    input logic              busy,
    input logic [SEC_W-1:0]  sec_now,
    input logic [USEC_W-1:0] usec_now
);
    logic [3:0] pos_q;

    // Independent byte-position tracker started by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= 4'd0;
        else if (stamp_stb)
            pos_q <= 4'd1;
        else if (pos_q == 4'd8)
            pos_q <= 4'd0;
        else if (pos_q != 4'd0)
            pos_q <= pos_q + 4'd1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!stamp_stb && !busy && stamp_byte == 8'd0 && usec_now == '0 && sec_now == '0));

    assert_usec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        usec_now < USEC_W'(USEC_LIMIT));

    assert_usec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (usec_tick && usec_now == USEC_W'(USEC_LIMIT - 1))
        |=> (usec_now == '0 && sec_now == $past(sec_now) + SEC_W'(1)));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_stb |=> !stamp_stb);

    assert_last_byte_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == 4'd8) |-> (stamp_byte == 8'd0));

    assert_idle_bus_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (stamp_byte == 8'd0));

    assert_request_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_req && !busy) |=> (stamp_stb && busy));

    assert_busy_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != 4'd0) |-> busy);

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == 4'd8) |=> !busy);

    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_req && busy) |=> !stamp_stb);
endmodule

bind ts_snapshot_serializer ts_snapshot_checker #(
    .SEC_W(SEC_W), .USEC_W(USEC_W), .USEC_LIMIT(USEC_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .usec_tick(usec_tick), .snap_req(snap_req),
    .stamp_stb(stamp_stb), .stamp_byte(stamp_byte), .busy(busy),
    .sec_now(sec_now), .usec_now(usec_now)
);

// File: tb/sim_ts_snapshot_serializer.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference model compared on every clock.
module sim_ts_snapshot_serializer;
    localparam int LIM    = 200;
    localparam int CYCLES = 9000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usec_tick = 1'b0;
    logic       snap_req = 1'b0;
    logic       stamp_stb;
    logic [7:0] stamp_byte;
    logic       busy;

    int vecs = 0;
    int fails = 0;

    // reference model state
    int unsigned m_sec = 0, m_usec = 0;
    bit          e_stb = 0, e_busy = 0;
    logic [7:0]  e_byte = 8'd0;
    logic [7:0]  byte_q[$];
    int unsigned cap_sec_q[$], cap_usec_q[$];

    // reassembly of the DUT's message
    int          col_n = -1;
    logic [63:0] col = '0;

    always #2.5 clk = ~clk;

    ts_snapshot_serializer #(.USEC_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .usec_tick(usec_tick), .snap_req(snap_req),
        .stamp_stb(stamp_stb), .stamp_byte(stamp_byte), .busy(busy)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model over the edge just passed, using the held inputs.
    task automatic model_step();
        bit         accept, popped;
        logic [7:0] nb;
        if (!rst_n) begin
            m_sec = 0; m_usec = 0; e_stb = 0; e_busy = 0; e_byte = 8'd0;
            byte_q.delete(); cap_sec_q.delete(); cap_usec_q.delete();
            return;
        end
        accept = snap_req && !e_busy;   // R9: ignored while busy
        popped = 0; nb = 8'd0;
        if (byte_q.size() > 0) begin nb = byte_q.pop_front(); popped = 1; end
        if (accept) begin
            for (int i = 0; i < 4; i++) byte_q.push_back(8'((m_sec >> (8*i)) & 32'hff));
            for (int i = 0; i < 3; i++) byte_q.push_back(8'((m_usec >> (8*i)) & 32'hff));
            byte_q.push_back(8'd0);
            cap_sec_q.push_back(m_sec);
            cap_usec_q.push_back(m_usec);
        end
        e_stb  = accept;
        e_byte = nb;
        e_busy = accept || popped;
        if (usec_tick) begin
            if (m_usec == LIM - 1) begin m_usec = 0; m_sec++; end
            else m_usec++;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            @(negedge clk);
            model_step();
            if (!rst_n) begin
                chk("R1 strobe in reset", 64'(stamp_stb), 64'(0));
                chk("R1 busy in reset", 64'(busy), 64'(0));
                chk("R1 byte in reset", 64'(stamp_byte), 64'(0));
            end else begin
                chk("R4 R9 strobe", 64'(stamp_stb), 64'(e_stb));
                chk("R5 R6 R7 byte", 64'(stamp_byte), 64'(e_byte));
                chk("R8 busy", 64'(busy), 64'(e_busy));
                // rebuild the captured pair from the bytes
                if (col_n >= 0) begin
                    col[col_n*8 +: 8] = stamp_byte;
                    col_n++;
                    if (col_n == 8) begin
                        col_n = -1;
                        if (cap_sec_q.size() > 0) begin
                            chk("R3 R5 seconds field", 64'(col[31:0]), 64'(cap_sec_q.pop_front()));
                            chk("R2 R3 usec field", 64'(col[63:32]), 64'(cap_usec_q.pop_front()));
                        end else begin
                            chk("R4 unexpected message", 64'(1), 64'(0));
                        end
                    end
                end
                if (stamp_stb) col_n = 0;
            end
            // drive next inputs
            rst_n = (cyc >= 5);
            if (cyc < 600) begin
                usec_tick = 1'b1;
                snap_req  = (cyc % 13 == 0);
            end else if (cyc < 3000) begin
                usec_tick = ($urandom % 4) != 0;
                snap_req  = ($urandom % 6) == 0;
            end else begin
                // requests landing on the microseconds wrap, plus some while busy
                usec_tick = 1'b1;
                snap_req  = (!e_busy && m_usec == LIM - 1) || (e_busy && cyc % 5 == 0);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule